// File: doc/BRIEF.md
# Host Bus Read Hazard Sequencer

This block sits on the host side of an asynchronous parallel bus and performs read cycles against a peripheral whose FIFO and counter registers need a minimum quiet interval between certain pairs of reads. A read request (register address plus a 16/32-bit width flag) enters on a valid/ready handshake. The block stores the class of the last register it really read and counts the clock cycles since that read ended. Before each new read it checks a table of forbidden pairs. When a pair is in the table, it keeps the strobes high until the required time has passed, or it fills the interval with harmless reads of a test register. The `pad_dummy` input selects between these two methods.

Each bus cycle drives the address one cycle before chip-select and read-strobe fall together. The strobes stay low for a fixed number of clocks. The data on the bus in the last low cycle is registered, with the upper half cleared for 16-bit reads, and is returned with a single-cycle valid pulse. Bus timing and hazard intervals are parameters. The intervals are given in nanoseconds and converted to clock cycles, rounding up, using the clock period parameter.

Top module: `hzd_read_seq`

## Requirements
- R1: After reset the strobes are high, `rsp_valid` is low, `req_ready` is high, and no previous read is on record, so the first read is never padded.
- R2: Every bus read, real or dummy, holds `bus_cs_n` and `bus_rd_n` low together for exactly CYC_CLKS consecutive clocks.
- R3: Between any two strobe pulses the strobes stay high for at least IDLE_CLKS clocks. When a request is already waiting and the pair is not a hazard, the high time is exactly IDLE_CLKS.
- R4: `bus_addr` changes only while the strobes are high. It holds its value from the cycle before the strobes fall until they rise.
- R5: The hazard pairs (previous real read, then next read) are: receive-data or receive-status, then receive-info; transmit-status, then transmit-info, both needing FIFO_WAIT_NS; drop-counter, then drop-counter, needing DROP_WAIT_NS. Each interval becomes ceil(ns / CLK_NS) clocks W, measured from the clock after the previous real read's strobes rise to the fall of the next one. All other pairs are free.
- R6: With `pad_dummy` = 0, a hazard pair with a request already waiting is separated by exactly max(IDLE_CLKS, W) high clocks and no other bus activity.
- R7: With `pad_dummy` = 1, a hazard pair is separated by k dummy reads at ADR_TEST, where k is the smallest count with (k+1)·IDLE_CLKS + k·CYC_CLKS ≥ W. Each bus cycle in the interval is preceded by exactly IDLE_CLKS high clocks.
- R8: Dummy reads produce no response and do not replace the recorded previous read.
- R9: `rsp_valid` is high for exactly one clock, the first clock after a real read's strobes rise. `rsp_data` then holds the value `bus_data` had in that read's last low clock.
- R10: For a read with `req_wide` = 0, `rsp_data[31:16]` is zero. With `req_wide` = 1 all 32 bits are returned.
- R11: A request is taken when `req_valid` and `req_ready` are both high. Only one request is held. Reads and their responses follow request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_dummy | input | 1 | 1: fill hazard intervals with test-register reads; 0: idle |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request slot free |
| req_addr | input | AW | Register address of the request |
| req_wide | input | 1 | 1: 32-bit read, 0: 16-bit read |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_data | input | DW | Read data from the peripheral |
| rsp_valid | output | 1 | One-clock pulse with returned data |
| rsp_data | output | DW | Captured read data |

## Verification
The bench builds the block with CLK_NS = 4, CYC_CLKS = 3 and IDLE_CLKS = 2. The hazard intervals then become 124 and 165 clocks. In dummy mode they need 25 and 33 filler reads, so each hazard interval stays within a few hundred cycles while the arithmetic is still tested. Under each padding mode, with a short bus cycle, it sweeps every ordered pair of eight addresses: the six classed registers, the test register and a plain register. The width alternates from read to read. Back-to-back requests let the bench predict every high interval, dummy count and pulse width exactly from the formulas in the requirements.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [2:0] {
      CLS_PLAIN,
      CLS_RX_DATA,
      CLS_RX_STAT,
      CLS_TX_STAT,
      CLS_RX_INFO,
      CLS_TX_INFO,
      CLS_DROP_CNT
   } rd_class_e;

   typedef enum logic [1:0] {
      PH_HIGH,
      PH_SETUP,
      PH_LOW
   } bus_phase_e;

endpackage

// File: rtl/hzd_classify.sv
module hzd_classify
   import hzd_pkg::*;
#(
   parameter int AW = 7,
   parameter logic [AW-1:0] ADR_RX_DATA = '0,
   parameter logic [AW-1:0] ADR_RX_STAT = '0,
   parameter logic [AW-1:0] ADR_TX_STAT = '0,
   parameter logic [AW-1:0] ADR_RX_INFO = '0,
   parameter logic [AW-1:0] ADR_TX_INFO = '0,
   parameter logic [AW-1:0] ADR_DROP    = '0
) (
   input  logic [AW-1:0] addr,
   output rd_class_e     cls
);

   always_comb begin
      if      (addr == ADR_RX_DATA) cls = CLS_RX_DATA;
      else if (addr == ADR_RX_STAT) cls = CLS_RX_STAT;
      else if (addr == ADR_TX_STAT) cls = CLS_TX_STAT;
      else if (addr == ADR_RX_INFO) cls = CLS_RX_INFO;
      else if (addr == ADR_TX_INFO) cls = CLS_TX_INFO;
      else if (addr == ADR_DROP)    cls = CLS_DROP_CNT;
      else                          cls = CLS_PLAIN;
   end

endmodule

// File: rtl/hzd_tracker.sv
module hzd_tracker
   import hzd_pkg::*;
#(
   parameter int CW      = 9,
   parameter int FIFO_WC = 50,
   parameter int DROP_WC = 66
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      commit,
   input  rd_class_e commit_cls,
   input  rd_class_e next_cls,
   output logic      hazard,
   output logic      wait_met
);

   rd_class_e        last_cls;
   logic [CW-1:0]    elapsed;
   logic [CW-1:0]    need;

   // elapsed = clocks since the last real read's strobes rose (1 in first high clock)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_cls <= CLS_PLAIN;
         elapsed  <= '1;
      end else if (commit) begin
         last_cls <= commit_cls;
         elapsed  <= CW'(1);
      end else if (elapsed != '1) begin
         elapsed  <= elapsed + 1'b1;
      end
   end

   always_comb begin
      need = '0;
      if ((last_cls == CLS_RX_DATA || last_cls == CLS_RX_STAT) && next_cls == CLS_RX_INFO)
         need = CW'(FIFO_WC);
      else if (last_cls == CLS_TX_STAT && next_cls == CLS_TX_INFO)
         need = CW'(FIFO_WC);
      else if (last_cls == CLS_DROP_CNT && next_cls == CLS_DROP_CNT)
         need = CW'(DROP_WC);
      hazard   = (need != '0);
      // decision is one setup clock before the strobes fall
      wait_met = !hazard || (elapsed >= need - CW'(1));
   end

endmodule

// File: rtl/hzd_bus_fsm.sv
module hzd_bus_fsm
   import hzd_pkg::*;
#(
   parameter int AW        = 7,
   parameter int DW        = 32,
   parameter int CYC_CLKS  = 17,
   parameter int IDLE_CLKS = 2,
   parameter bit NARROW_EN = 1'b1,
   parameter logic [AW-1:0] ADR_TEST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pad_dummy,
   input  logic          pend,
   input  logic [AW-1:0] pend_addr,
   input  logic          pend_wide,
   input  logic          hazard,
   input  logic          wait_met,
   output logic          take,
   output logic          commit,
   output logic          bus_cs_n,
   output logic          bus_rd_n,
   output logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);

   localparam int GW = $clog2(IDLE_CLKS + 1) + 1;
   localparam int LW = $clog2(CYC_CLKS + 1);

   bus_phase_e    phase;
   logic [GW-1:0] gap;
   logic [LW-1:0] lcnt;
   logic          cur_dummy;
   logic          cur_wide;
   logic          at_end;
   logic          slot;
   logic          go_real;
   logic          go_dummy;
   logic [DW-1:0] cap_data;

   always_comb begin
      at_end   = (phase == PH_LOW) && (lcnt == LW'(CYC_CLKS - 1));
      commit   = at_end && !cur_dummy;
      slot     = (phase == PH_HIGH) && pend && (gap >= GW'(IDLE_CLKS - 1));
      go_real  = slot && wait_met;
      go_dummy = slot && hazard && !wait_met && pad_dummy;
      take     = go_real;
   end

   generate
      if (NARROW_EN) begin : g_narrow
         assign cap_data = cur_wide ? bus_data : {{(DW/2){1'b0}}, bus_data[DW/2-1:0]};
      end else begin : g_wide_only
         assign cap_data = bus_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_HIGH;
         gap       <= '1;
         lcnt      <= '0;
         cur_dummy <= 1'b0;
         cur_wide  <= 1'b1;
         bus_addr  <= '0;
      end else begin
         unique case (phase)
            PH_HIGH: begin
               if (gap != '1) gap <= gap + 1'b1;
               if (go_real) begin
                  phase     <= PH_SETUP;
                  bus_addr  <= pend_addr;
                  cur_dummy <= 1'b0;
                  cur_wide  <= pend_wide;
               end else if (go_dummy) begin
                  phase     <= PH_SETUP;
                  bus_addr  <= ADR_TEST;
                  cur_dummy <= 1'b1;
               end
            end
            PH_SETUP: begin
               if (gap != '1) gap <= gap + 1'b1;
               phase <= PH_LOW;
               lcnt  <= '0;
            end
            default: begin
               if (at_end) begin
                  phase <= PH_HIGH;
                  gap   <= GW'(1);
               end else begin
                  lcnt  <= lcnt + 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= commit;
         if (commit) rsp_data <= cap_data;
      end
   end

   assign bus_cs_n = (phase != PH_LOW);
   assign bus_rd_n = (phase != PH_LOW);

endmodule

// File: rtl/hzd_read_seq.sv
module hzd_read_seq
   import hzd_pkg::*;
#(
   parameter int AW           = 7,
   parameter int DW           = 32,
   parameter int CLK_NS       = 10,
   parameter int CYC_CLKS     = 17,
   parameter int IDLE_CLKS    = 2,
   parameter int FIFO_WAIT_NS = 495,
   parameter int DROP_WAIT_NS = 660,
   parameter bit NARROW_EN    = 1'b1,
   parameter logic [AW-1:0] ADR_RX_DATA = 7'h00,
   parameter logic [AW-1:0] ADR_RX_STAT = 7'h20,
   parameter logic [AW-1:0] ADR_TX_STAT = 7'h24,
   parameter logic [AW-1:0] ADR_RX_INFO = 7'h3C,
   parameter logic [AW-1:0] ADR_TX_INFO = 7'h40,
   parameter logic [AW-1:0] ADR_DROP    = 7'h34,
   parameter logic [AW-1:0] ADR_TEST    = 7'h32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pad_dummy,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic          req_wide,
   output logic          bus_cs_n,
   output logic          bus_rd_n,
   output logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);

   localparam int FIFO_WC = (FIFO_WAIT_NS + CLK_NS - 1) / CLK_NS;
   localparam int DROP_WC = (DROP_WAIT_NS + CLK_NS - 1) / CLK_NS;
   localparam int MAX_WC  = (FIFO_WC > DROP_WC) ? FIFO_WC : DROP_WC;
   localparam int CW      = $clog2(MAX_WC + 3) + 1;

   generate
      if (IDLE_CLKS < 2) begin : g_bad_idle
         $error("IDLE_CLKS must be at least 2");
      end
      if (CYC_CLKS < 1) begin : g_bad_cyc
         $error("CYC_CLKS must be at least 1");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be at least 1");
      end
      if (DW % 2 != 0) begin : g_bad_dw
         $error("DW must be even");
      end
   endgenerate

   logic          pend;
   logic [AW-1:0] pend_addr;
   logic          pend_wide;
   logic          take;
   logic          commit;
   logic          hazard;
   logic          wait_met;
   rd_class_e     next_cls;
   rd_class_e     done_cls;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
         pend_wide <= 1'b0;
      end else if (take) begin
         pend      <= 1'b0;
      end else if (req_valid && !pend) begin
         pend      <= 1'b1;
         pend_addr <= req_addr;
         pend_wide <= req_wide;
      end
   end

   assign req_ready = !pend;

   hzd_classify #(
      .AW(AW), .ADR_RX_DATA(ADR_RX_DATA), .ADR_RX_STAT(ADR_RX_STAT),
      .ADR_TX_STAT(ADR_TX_STAT), .ADR_RX_INFO(ADR_RX_INFO),
      .ADR_TX_INFO(ADR_TX_INFO), .ADR_DROP(ADR_DROP)
   ) u_cls_next (
      .addr(pend_addr),
      .cls (next_cls)
   );

   hzd_classify #(
      .AW(AW), .ADR_RX_DATA(ADR_RX_DATA), .ADR_RX_STAT(ADR_RX_STAT),
      .ADR_TX_STAT(ADR_TX_STAT), .ADR_RX_INFO(ADR_RX_INFO),
      .ADR_TX_INFO(ADR_TX_INFO), .ADR_DROP(ADR_DROP)
   ) u_cls_done (
      .addr(bus_addr),
      .cls (done_cls)
   );

   hzd_tracker #(
      .CW(CW), .FIFO_WC(FIFO_WC), .DROP_WC(DROP_WC)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .commit_cls(done_cls),
      .next_cls  (next_cls),
      .hazard    (hazard),
      .wait_met  (wait_met)
   );

   hzd_bus_fsm #(
      .AW(AW), .DW(DW), .CYC_CLKS(CYC_CLKS), .IDLE_CLKS(IDLE_CLKS),
      .NARROW_EN(NARROW_EN), .ADR_TEST(ADR_TEST)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_dummy(pad_dummy),
      .pend     (pend),
      .pend_addr(pend_addr),
      .pend_wide(pend_wide),
      .hazard   (hazard),
      .wait_met (wait_met),
      .take     (take),
      .commit   (commit),
      .bus_cs_n (bus_cs_n),
      .bus_rd_n (bus_rd_n),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data)
   );

endmodule

// File: rtl/hzd_read_seq_chk.sv
module hzd_read_seq_chk #(
   parameter int AW        = 7,
   parameter int CYC_CLKS  = 17,
   parameter int IDLE_CLKS = 2,
   parameter int FIFO_WC   = 50,
   parameter int DROP_WC   = 66,
   parameter int CW        = 9,
   parameter logic [AW-1:0] ADR_RX_DATA = '0,
   parameter logic [AW-1:0] ADR_RX_STAT = '0,
   parameter logic [AW-1:0] ADR_TX_STAT = '0,
   parameter logic [AW-1:0] ADR_RX_INFO = '0,
   parameter logic [AW-1:0] ADR_TX_INFO = '0,
   parameter logic [AW-1:0] ADR_DROP    = '0,
   parameter logic [AW-1:0] ADR_TEST    = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_rd_n,
   input logic [AW-1:0] bus_addr,
   input logic          rsp_valid
);

   localparam int LCW = $clog2(CYC_CLKS + 2) + 1;
   localparam int HCW = $clog2(IDLE_CLKS + 2) + 1;

   logic [LCW-1:0] lo_cnt;
   logic [HCW-1:0] hi_cnt;
   logic [CW-1:0]  since;
   logic [AW-1:0]  last_real;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt    <= '0;
         hi_cnt    <= '0;
         since     <= '1;
         last_real <= ADR_TEST;
      end else begin
         if (!bus_rd_n) begin
            lo_cnt <= (lo_cnt != '1) ? lo_cnt + 1'b1 : lo_cnt;
            hi_cnt <= '0;
         end else begin
            lo_cnt <= '0;
            hi_cnt <= (hi_cnt != '1) ? hi_cnt + 1'b1 : hi_cnt;
         end
         if (rsp_valid) begin
            since     <= CW'(2);
            last_real <= bus_addr;
         end else if (since != '1) begin
            since     <= since + 1'b1;
         end
      end
   end

   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd_n) |-> (lo_cnt == LCW'(CYC_CLKS)));  // R2
   AST_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rd_n) |-> (hi_cnt >= HCW'(IDLE_CLKS)));  // R3
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> $stable(bus_addr));  // R4
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);  // R9
   AST_RSP_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(bus_rd_n));  // R9
   AST_RX_INFO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) && bus_addr == ADR_RX_INFO &&
       (last_real == ADR_RX_DATA || last_real == ADR_RX_STAT))
      |-> (since > CW'(FIFO_WC)));  // R5
   AST_TX_INFO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) && bus_addr == ADR_TX_INFO && last_real == ADR_TX_STAT)
      |-> (since > CW'(FIFO_WC)));  // R5
   AST_DROP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) && bus_addr == ADR_DROP && last_real == ADR_DROP)
      |-> (since > CW'(DROP_WC)));  // R5

endmodule

bind hzd_read_seq hzd_read_seq_chk #(
   .AW(AW), .CYC_CLKS(CYC_CLKS), .IDLE_CLKS(IDLE_CLKS),
   .FIFO_WC(FIFO_WC), .DROP_WC(DROP_WC), .CW(CW),
   .ADR_RX_DATA(ADR_RX_DATA), .ADR_RX_STAT(ADR_RX_STAT), .ADR_TX_STAT(ADR_TX_STAT),
   .ADR_RX_INFO(ADR_RX_INFO), .ADR_TX_INFO(ADR_TX_INFO), .ADR_DROP(ADR_DROP),
   .ADR_TEST(ADR_TEST)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_rd_n (bus_rd_n),
   .bus_addr (bus_addr),
   .rsp_valid(rsp_valid)
);

// File: tb/hzd_read_seq_test.sv
module hzd_read_seq_test;

   localparam int AW = 7;
   localparam int DW = 32;
   localparam int CLKNS = 4;
   localparam int CYC = 3;
   localparam int IDL = 2;
   localparam int FNS = 495;
   localparam int DNS = 660;
   localparam int FWC = (FNS + CLKNS - 1) / CLKNS;
   localparam int DWC = (DNS + CLKNS - 1) / CLKNS;
   localparam int NREQ = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pad_dummy = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_wide = 1'b0;
   logic          bus_cs_n, bus_rd_n;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;

   always #2 clk = ~clk;

   function automatic logic [AW-1:0] addr_of(input int i);
      case (i)
         1: return 7'h00;  // receive data
         2: return 7'h20;  // receive status
         3: return 7'h24;  // transmit status
         4: return 7'h3C;  // receive info
         5: return 7'h40;  // transmit info
         6: return 7'h34;  // drop counter
         7: return 7'h32;  // test register
         default: return 7'h50;
      endcase
   endfunction

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {8'hC3, 1'b1, a, 8'h5A, 1'b0, a};
   endfunction

   function automatic int wait_clks(input int p, input int n);
      if ((p == 1 || p == 2) && n == 4) return FWC;
      if (p == 3 && n == 5) return FWC;
      if (p == 6 && n == 6) return DWC;
      return 0;
   endfunction

   assign bus_data = pat(bus_addr);

   hzd_read_seq #(
      .AW(AW), .DW(DW), .CLK_NS(CLKNS), .CYC_CLKS(CYC), .IDLE_CLKS(IDL),
      .FIFO_WAIT_NS(FNS), .DROP_WAIT_NS(DNS), .NARROW_EN(1'b1),
      .ADR_RX_DATA(7'h00), .ADR_RX_STAT(7'h20), .ADR_TX_STAT(7'h24),
      .ADR_RX_INFO(7'h3C), .ADR_TX_INFO(7'h40), .ADR_DROP(7'h34), .ADR_TEST(7'h32)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pad_dummy(pad_dummy),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_wide(req_wide),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   int req_idx [NREQ];
   bit req_w   [NREQ];
   bit req_dm  [NREQ];
   bit req_1st [NREQ];
   int sent = 0;
   int rcvd = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic send(input int idx, input bit w, input bit first);
      req_idx[sent] = idx;
      req_w[sent]   = w;
      req_dm[sent]  = pad_dummy;
      req_1st[sent] = first;
      sent++;
      req_valid = 1'b1;
      req_addr  = addr_of(idx);
      req_wide  = w;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // bus monitor
   bit            prev_rd = 1'b1;
   bit            prev_rsp = 1'b0;
   int            lo_len = 0;
   int            hi_len = 1000;
   int            since_real = 100000;
   int            last_gap = 0;
   int            tot_gap = 0;
   int            pulse_w = 0;
   int            pulses = 0;
   int            bad_dummy = 0;
   logic [AW-1:0] last_addr = '0;
   logic [AW-1:0] setup_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!bus_rd_n) begin
            if (prev_rd) begin
               last_gap = hi_len;
               tot_gap  = since_real;
               chk(bus_addr == setup_addr, "R4 address set up before strobe", bus_addr, setup_addr);
               if (pulses > 0 && last_addr != 7'h32) bad_dummy++;
               pulses++;
               last_addr = bus_addr;
               lo_len = 0;
            end else if (bus_addr != last_addr) begin
               chk(1'b0, "R4 address held during strobe", bus_addr, last_addr);
            end
            chk(bus_cs_n == 1'b0, "R2 chip-select with strobe", bus_cs_n, 0);
            lo_len++;
         end else begin
            if (!prev_rd) begin
               pulse_w = lo_len;
               hi_len = 1;
            end else begin
               hi_len++;
            end
         end
         if (rsp_valid && prev_rsp) chk(1'b0, "R9 response longer than one clock", 2, 1);
         if (rsp_valid && bus_rd_n && prev_rd)
            chk(1'b0, "R9 response not in first high clock", 0, 1);
         if (rsp_valid) begin
            if (rcvd >= sent) begin
               chk(1'b0, "R11 response without request", rcvd, sent);
            end else begin
               int idx, wc, k, etot, elast;
               logic [DW-1:0] ed;
               idx = req_idx[rcvd];
               ed  = pat(addr_of(idx));
               if (!req_w[rcvd]) ed[31:16] = '0;
               chk(rsp_data == ed, req_w[rcvd] ? "R9 wide data" : "R10 narrow data", rsp_data, ed);
               chk(pulse_w == CYC, "R2 strobe width", pulse_w, CYC);
               chk(last_addr == addr_of(idx), "R11 read order", last_addr, addr_of(idx));
               chk(bad_dummy == 0, "R8 filler read address", bad_dummy, 0);
               if (req_1st[rcvd]) begin
                  chk(pulses == 1, "R1 no padding on first read", pulses - 1, 0);
                  chk(tot_gap >= IDL, "R3 minimum high time", tot_gap, IDL);
               end else begin
                  wc = wait_clks(req_idx[rcvd-1], idx);
                  k = 0;
                  if (wc == 0) begin
                     etot = IDL; elast = IDL;
                  end else if (!req_dm[rcvd]) begin
                     etot = (IDL > wc) ? IDL : wc; elast = etot;
                  end else begin
                     while ((k + 1) * IDL + k * CYC < wc) k++;
                     etot = (k + 1) * IDL + k * CYC; elast = IDL;
                  end
                  chk(pulses - 1 == k, "R7 filler read count", pulses - 1, k);
                  chk(tot_gap == etot,
                      wc == 0 ? "R3 free pair gap" : (req_dm[rcvd] ? "R7 padded gap" : "R6 idle gap"),
                      tot_gap, etot);
                  chk(last_gap == elast, "R5 high time before read", last_gap, elast);
               end
            end
            rcvd++;
            pulses = 0;
            bad_dummy = 0;
            since_real = 1;
         end else begin
            since_real++;
         end
         prev_rd    = bus_rd_n;
         prev_rsp   = rsp_valid;
         setup_addr = bus_addr;
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(bus_cs_n == 1'b1, "R1 chip-select idle", bus_cs_n, 1);
      chk(bus_rd_n == 1'b1, "R1 strobe idle", bus_rd_n, 1);
      chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      for (int m = 0; m < 2; m++) begin
         bit first;
         pad_dummy = m[0];
         first = 1'b1;
         for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
               send(a, ((a + b) % 2) == 0, first);
               first = 1'b0;
               send(b, ((a + b) % 2) == 1, 1'b0);
            end
         end
         while (rcvd < sent) @(negedge clk);
         repeat (5) @(negedge clk);
      end
      chk(rcvd == NREQ, "R11 response count", rcvd, NREQ);
      chk(rsp_valid == 1'b0 && bus_rd_n == 1'b1, "R8 no stray activity", rsp_valid, 0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R11 watchdog: responses %0d expected %0d", rcvd, NREQ);
         summary();
         $finish;
      end
   end

endmodule